// File: doc/BRIEF.md
# Double-Buffered Reference Code Bank

This block keeps the ten-bit codes for sixteen reference converters: fourteen gamma channels (indices 0 to 13) and two common-voltage channels (indices 14 and 15). Every channel has two registers. A staging register takes the value written by the serial front end, and an output register drives the converter. The front end delivers a channel index, a 16-bit data word and a one-cycle write strobe.

A hold pin sets when staged values reach the outputs. With hold low, each write goes straight through. With hold high, the outputs keep their values while writes collect in the staging registers. The staged set reaches the outputs when the pin drops, or when a write carries the global-transfer command. Command codes in the top bits of the data word can also return one channel or every channel to its default code. The default codes come from a one-time memory and are used only when its "programmed" flag is set. Otherwise the default is zero. A power-up reset or a general-call reset pulse loads these defaults into both register sets.

Top module: `dacbank_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every channel takes its default code from the next cycle on. That default is the channel's `dflt_codes` slice when `dflt_valid` is 1, and zero when it is 0.
- R2: A `gc_rst` pulse loads the same defaults into every channel one cycle later, whatever the hold pin and any write in that cycle.
- R3: With `hold_ld` low, a valid write with data bits 15:14 not equal to 2'b11 shows the code in data bits 9:0 on that channel's output in the next cycle.
- R4: With `hold_ld` high, a write whose data bit 15 is 0 changes no output.
- R5: In the cycle after `hold_ld` is sampled low, every output equals its channel's staging value.
- R6: A valid write with data bits 15:14 = 2'b10 stores its code, then copies all sixteen staging registers to the outputs in the same cycle, even while `hold_ld` is high.
- R7: Data bits 13:10 of a plain write (bits 15:14 = 2'b00 or 2'b01) have no effect on the stored code.
- R8: A valid write with data bits 15:13 = 3'b111 resets the staging and output registers of every channel to their defaults. The index value plays no part.
- R9: A valid write with data bits 15:13 = 3'b110 resets both registers of the indexed channel only.
- R10: A write whose index is 16 or more is discarded whatever its command, and no register changes.
- R11: Every reset loads the staging registers as well as the outputs, so a later hold release brings back no value from before the reset.
- R12: When `dflt_valid` is 0, every reset path loads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset (loads defaults) |
| gc_rst | input | 1 | General-call reset pulse (loads defaults) |
| hold_ld | input | 1 | High: outputs hold; low: outputs follow staging |
| dflt_valid | input | 1 | One-time memory programmed flag |
| dflt_codes | input | 160 | Default codes, channel i at bits [10*i+9:10*i] |
| wr_en | input | 1 | One-cycle write strobe |
| wr_idx | input | 5 | Channel index of the write |
| wr_data | input | 16 | Command bits 15:13, code bits 9:0 |
| out_codes | output | 160 | Output codes, channel i at bits [10*i+9:10*i] |

## Verification
The bench builds the block with its default parameters: sixteen channels, ten-bit codes and a 16-bit word. The index port is one bit wider than sixteen channels need, so the bench can drive the unused indices 16 to 31 and drive the discard path with plain, transfer and reset commands. The default codes differ from channel to channel, and the bench switches the programmed flag off for one reset. This tells a correct default apart from zero and from a code that was left behind.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    // Operation carried by the top bits of a data word
    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_XFER    = 2'd1,
        OP_RST_ALL = 2'd2,
        OP_RST_ONE = 2'd3
    } dac_op_e;

    localparam int CMD_MSB   = 15;
    localparam int CMD_LSB   = 14;
    localparam int SCOPE_BIT = 13;

    function automatic dac_op_e classify(input logic [1:0] cmd, input logic scope);
        dac_op_e op;
        case (cmd)
            2'b10:   op = OP_XFER;
            2'b11:   op = scope ? OP_RST_ALL : OP_RST_ONE;
            default: op = OP_WRITE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CODE_W = 10,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0] load_sel,
    output logic [NUM_CH-1:0] clr_sel,
    output logic              xfer_all,
    output logic [CODE_W-1:0] code
);

    localparam logic [IDX_W-1:0] CH_LIMIT = IDX_W'(NUM_CH);

    logic    idx_ok;
    logic    accept;
    dac_op_e op;

    always_comb begin
        idx_ok   = (wr_idx < CH_LIMIT);
        accept   = wr_en && idx_ok;
        op       = classify(wr_data[CMD_MSB:CMD_LSB], wr_data[SCOPE_BIT]);
        xfer_all = accept && (op == OP_XFER);
        code     = wr_data[CODE_W-1:0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        logic hit;
        assign hit         = accept && (wr_idx == IDX_W'(i));
        assign load_sel[i] = hit && ((op == OP_WRITE) || (op == OP_XFER));
        assign clr_sel[i]  = (accept && (op == OP_RST_ALL)) ||
                             (hit && (op == OP_RST_ONE));
    end

endmodule

// File: rtl/dacbank_channel.sv
module dacbank_channel #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gc_rst,
    input  logic              dflt_valid,
    input  logic [CODE_W-1:0] dflt_code,
    input  logic              hold,
    input  logic              xfer_all,
    input  logic              load,
    input  logic              clr,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] out_code
);

    typedef struct packed {
        logic [CODE_W-1:0] stage;
        logic [CODE_W-1:0] drive;
    } ch_state_t;

    ch_state_t         st_q;
    ch_state_t         st_d;
    ch_state_t         st_rst;
    logic [CODE_W-1:0] dflt_eff;

    always_comb begin
        dflt_eff     = dflt_valid ? dflt_code : '0;
        st_rst.stage = dflt_eff;
        st_rst.drive = dflt_eff;
        st_d         = st_q;
        if (gc_rst || clr) begin
            st_d = st_rst;
        end else begin
            if (load) begin
                st_d.stage = code;
            end
            if (!hold || xfer_all) begin
                st_d.drive = st_d.stage;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_code = st_q.drive;

endmodule

// File: rtl/dacbank_top.sv
module dacbank_top #(
    parameter int NUM_CH = 16,
    parameter int CODE_W = 10,
    parameter int DATA_W = 16,
    parameter int IDX_W  = $clog2(NUM_CH) + 1,
    parameter int BUS_W  = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gc_rst,
    input  logic              hold_ld,
    input  logic              dflt_valid,
    input  logic [BUS_W-1:0]  dflt_codes,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BUS_W-1:0]  out_codes
);

    logic [NUM_CH-1:0] load_sel;
    logic [NUM_CH-1:0] clr_sel;
    logic              xfer_all;
    logic [CODE_W-1:0] code;

    dacbank_decode #(
        .NUM_CH(NUM_CH),
        .CODE_W(CODE_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .load_sel(load_sel),
        .clr_sel (clr_sel),
        .xfer_all(xfer_all),
        .code    (code)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dacbank_channel #(
            .CODE_W(CODE_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .gc_rst    (gc_rst),
            .dflt_valid(dflt_valid),
            .dflt_code (dflt_codes[i*CODE_W +: CODE_W]),
            .hold      (hold_ld),
            .xfer_all  (xfer_all),
            .load      (load_sel[i]),
            .clr       (clr_sel[i]),
            .code      (code),
            .out_code  (out_codes[i*CODE_W +: CODE_W])
        );
    end

endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk #(
    parameter int NUM_CH = 16,
    parameter int CODE_W = 10,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5,
    parameter int BUS_W  = NUM_CH * CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gc_rst,
    input logic              hold_ld,
    input logic              dflt_valid,
    input logic [BUS_W-1:0]  dflt_codes,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [BUS_W-1:0]  out_codes
);

    localparam logic [IDX_W-1:0] CH_LIMIT = IDX_W'(NUM_CH);

    logic [BUS_W-1:0]  dflt_eff;
    logic [IDX_W-1:0]  last_idx;
    logic [CODE_W-1:0] last_code;
    logic [CODE_W-1:0] cur_ch;

    assign dflt_eff = dflt_valid ? dflt_codes : '0;
    assign cur_ch   = out_codes[int'(last_idx)*CODE_W +: CODE_W];

    always_ff @(posedge clk) begin
        last_idx  <= wr_idx;
        last_code <= wr_data[CODE_W-1:0];
    end

    // R2, R12: general-call reset loads defaults or zero
    p_gc_defaults_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gc_rst |=> (out_codes == $past(dflt_eff)));

    // R3: transparent write reaches its channel next cycle
    p_transparent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx < CH_LIMIT) && !hold_ld && !gc_rst && (wr_data[15:14] != 2'b11))
        |=> (cur_ch == last_code));

    // R4: hold keeps all outputs during plain writes
    p_hold_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ld && !gc_rst && !(wr_en && wr_data[15])) |=> $stable(out_codes));

    // R10: out-of-range index changes nothing
    p_bad_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx >= CH_LIMIT) && hold_ld && !gc_rst) |=> $stable(out_codes));

endmodule

bind dacbank_top dacbank_chk #(
    .NUM_CH(NUM_CH),
    .CODE_W(CODE_W),
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gc_rst    (gc_rst),
    .hold_ld   (hold_ld),
    .dflt_valid(dflt_valid),
    .dflt_codes(dflt_codes),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .out_codes (out_codes)
);

// File: tb/tb_dacbank_top.sv
module tb_dacbank_top;

    localparam int NUM_CH = 16;
    localparam int CODE_W = 10;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 5;
    localparam int BUS_W  = NUM_CH * CODE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              gc_rst = 1'b0;
    logic              hold_ld = 1'b0;
    logic              dflt_valid = 1'b1;
    logic [BUS_W-1:0]  dflt_codes;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [BUS_W-1:0]  out_codes;

    int n_checks = 0;
    int n_bad    = 0;

    always #2.5 clk = ~clk;

    dacbank_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .gc_rst    (gc_rst),
        .hold_ld   (hold_ld),
        .dflt_valid(dflt_valid),
        .dflt_codes(dflt_codes),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .out_codes (out_codes)
    );

    function automatic logic [CODE_W-1:0] dflt_of(input int ch);
        return CODE_W'((ch * 37 + 5) % 1024);
    endfunction

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            dflt_codes[i*CODE_W +: CODE_W] = dflt_of(i);
        end
    end

    typedef struct packed {
        logic              hold;
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic [4:0]        ch;
        logic [CODE_W-1:0] exp;
        logic [3:0]        req;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 5'd3,  16'h0155, 5'd3,  10'h155, 4'd3},   // R3
        '{1'b0, 1'b1, 5'd15, 16'h03FF, 5'd15, 10'h3FF, 4'd3},   // R3
        '{1'b0, 1'b1, 5'd0,  16'h3CAA, 5'd0,  10'h0AA, 4'd7},   // R7 bits 13:10 set
        '{1'b1, 1'b1, 5'd3,  16'h0011, 5'd3,  10'h155, 4'd4},   // R4
        '{1'b1, 1'b1, 5'd4,  16'h0022, 5'd4,  10'h099, 4'd4},   // R4
        '{1'b1, 1'b1, 5'd16, 16'h0033, 5'd0,  10'h0AA, 4'd10},  // R10
        '{1'b0, 1'b0, 5'd0,  16'h0000, 5'd3,  10'h011, 4'd5},   // R5 release
        '{1'b0, 1'b0, 5'd0,  16'h0000, 5'd4,  10'h022, 4'd5},   // R5
        '{1'b1, 1'b1, 5'd6,  16'h0123, 5'd6,  10'h0E3, 4'd4},   // R4
        '{1'b1, 1'b1, 5'd5,  16'h8077, 5'd5,  10'h077, 4'd6},   // R6 transfer
        '{1'b1, 1'b0, 5'd0,  16'h0000, 5'd6,  10'h123, 4'd6},   // R6 all staged
        '{1'b1, 1'b1, 5'd6,  16'h0200, 5'd6,  10'h123, 4'd4},   // R4
        '{1'b1, 1'b1, 5'd6,  16'hC000, 5'd6,  10'h0E3, 4'd9},   // R9 one channel
        '{1'b1, 1'b0, 5'd0,  16'h0000, 5'd5,  10'h077, 4'd9},   // R9 others kept
        '{1'b1, 1'b1, 5'd31, 16'hC000, 5'd0,  10'h0AA, 4'd10},  // R10
        '{1'b0, 1'b0, 5'd0,  16'h0000, 5'd6,  10'h0E3, 4'd11},  // R11 staging reset
        '{1'b1, 1'b1, 5'd1,  16'h0300, 5'd1,  10'h02A, 4'd4},   // R4
        '{1'b1, 1'b1, 5'd2,  16'hE000, 5'd0,  10'h005, 4'd8},   // R8 all channels
        '{1'b1, 1'b1, 5'd2,  16'h0111, 5'd2,  10'h04F, 4'd4},   // R4
        '{1'b1, 1'b1, 5'd16, 16'h8000, 5'd2,  10'h04F, 4'd10},  // R10 transfer dropped
        '{1'b0, 1'b0, 5'd0,  16'h0000, 5'd1,  10'h02A, 4'd8},   // R8 staging cleared
        '{1'b0, 1'b0, 5'd0,  16'h0000, 5'd2,  10'h111, 4'd5},   // R5
        '{1'b0, 1'b1, 5'd16, 16'h0155, 5'd15, 10'h230, 4'd10}   // R10
    };

    task automatic check(input string tag, input int ch, input logic [CODE_W-1:0] exp);
        logic [CODE_W-1:0] act;
        act = out_codes[ch*CODE_W +: CODE_W];
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d actual=%h expected=%h", tag, ch, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NUM_CH; i++) check("R1 power-up default", i, dflt_of(i));

        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            hold_ld = VEC[k].hold;
            wr_en   = VEC[k].we;
            wr_idx  = VEC[k].idx;
            wr_data = VEC[k].data;
            @(negedge clk);
            wr_en = 1'b0;
            check($sformatf("R%0d vector %0d", VEC[k].req, k), int'(VEC[k].ch), VEC[k].exp);
        end

        // R2, R12: general-call reset with unprogrammed memory, concurrent write ignored
        @(negedge clk);
        dflt_valid = 1'b0;
        gc_rst  = 1'b1;
        wr_en   = 1'b1;
        wr_idx  = 5'd7;
        wr_data = 16'h0321;
        @(negedge clk);
        gc_rst = 1'b0;
        wr_en  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) check("R2 R12 general-call zero", i, '0);

        // R1: power-up reset under hold
        dflt_valid = 1'b1;
        hold_ld = 1'b1;
        rst_n   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NUM_CH; i++) check("R1 reset default", i, dflt_of(i));

        // R11: releasing hold after reset shows defaults, not stale data
        hold_ld = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NUM_CH; i++) check("R11 release after reset", i, dflt_of(i));

        report();
    end

endmodule